// File: doc/BRIEF.md
# Binary Heap Priority Queue

This block keeps a set of (key, tag) entries ordered as a max-heap, so the entry with the largest key is always at the root. The heap is a linear array that starts at index 1. Each tree level has its own small storage array. That lets a node, its parent and both of its children be read in the same cycle, and lets two entries on different levels be written in one cycle. A small address decoder turns a heap index into a level select and an in-level offset, and it is used for every read and write port.

Commands use a valid/ready handshake with three operations: insert, remove-top and look-at-top. A look-at-top answers on the next cycle and leaves the heap unchanged. An insert is taken in one cycle: the new entry is written at the first free position at the bottom, then climbs toward the root through one parent compare-and-swap per cycle. A remove-top returns the root on the next cycle. It then moves the last entry to the root and lets it sink one level per cycle. While either reordering runs, `busy` is high and new commands are held off. Keys that are equal never swap.

Top module: `bheap_pq`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full` is 0, `busy` is 0, `cmdReady` is 1, and `topValid`, `rspValid` and `cmdErr` are 0.
- R2: An insert (`cmdOp` = 2'b01) taken while not full raises `count` by one. Once `busy` falls, `topKey` equals the largest key held.
- R3: A look-at-top (`cmdOp` = 2'b11) taken while not empty gives `rspValid` for one cycle on the cycle after acceptance, carrying the root's key and tag. It leaves `count` unchanged and does not raise `busy`.
- R4: A remove-top (`cmdOp` = 2'b10) taken while not empty gives `rspValid` on the next cycle, carrying the key and tag that were at the root. `count` drops by one and `busy` is high while the heap reorders.
- R5: Successive remove-tops return keys in non-increasing order. A larger key means a higher priority.
- R6: An entry whose key equals its parent's key is not swapped with it. Among equal keys, the one that reached the root first stays there.
- R7: An insert while `full`, or a remove-top or look-at-top while `empty`, raises `cmdErr` for one cycle on the next cycle. It produces no response and leaves `count` unchanged.
- R8: `cmdReady` is low while `busy` is high. A command presented then is not taken, and `count` does not change during busy cycles.
- R9: After any accepted insert or remove-top, `busy` stays high for at most LEVELS consecutive cycles.
- R10: `full` is high exactly when `count` equals 2^LEVELS − 1. `empty` is high exactly when `count` is 0. `topValid` is high when the heap is non-empty and not busy.
- R11: A handshake with `cmdOp` = 2'b00 has no effect: no response, no error and no change to `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be taken this cycle |
| cmdOp | input | 2 | 00 none, 01 insert, 10 remove-top, 11 look-at-top |
| cmdKey | input | KEY_W | Key of the entry to insert |
| cmdTag | input | TAG_W | Tag carried with the inserted key |
| rspValid | output | 1 | One-cycle response strobe |
| rspKey | output | KEY_W | Key returned by remove-top or look-at-top |
| rspTag | output | TAG_W | Tag returned with rspKey |
| cmdErr | output | 1 | One-cycle pulse for a rejected command |
| topValid | output | 1 | Root output is settled and meaningful |
| topKey | output | KEY_W | Key at the root |
| topTag | output | TAG_W | Tag at the root |
| count | output | LEVELS | Number of entries held |
| full | output | 1 | Heap is at capacity |
| empty | output | 1 | Heap holds nothing |
| busy | output | 1 | Climb or sink reordering in progress |

## Verification
The heap is first filled with keys in scrambled order, so inserts stop at various depths. One of them is a new maximum that climbs from the deepest level while a command is held against it. A full drain must then give the keys in descending order, which separates a correct sink from one that takes the wrong child or stops early. An interleaved run of inserts and removals with distinct keys checks reordering on partly filled trees of every size. A final run with equal keys separates a strict comparison from one that swaps on ties, by the tag that ends up at the root. Boundary runs at empty and full, and a no-op command, show that rejected or empty handshakes change nothing.

// File: rtl/bheap_pkg.sv
package bheap_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ENQ  = 2'd1,
    OP_DEQ  = 2'd2,
    OP_PEEK = 2'd3
  } heapOpE;

  // strobes from control to storage
  typedef struct packed {
    logic enqWr;     // write new entry at bottom
    logic deqStart;  // move last entry to root
    logic swapUp;    // swap node with parent
    logic swapDown;  // swap node with chosen child
    logic rspLoad;   // capture root into response register
  } heapStrobeT;

endpackage

// File: rtl/bheap_addr_dec.sv
module bheap_addr_dec #(
  parameter int LEVELS = 4,
  parameter int IW     = LEVELS + 1
) (
  input  logic [IW-1:0]     idx,
  output logic [LEVELS-1:0] lvlSel,
  output logic [LEVELS-2:0] off
);
  localparam int OW = LEVELS - 1;

  always_comb begin
    lvlSel = '0;
    off    = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if ((idx >> l) == IW'(1)) begin
        lvlSel[l] = 1'b1;
        off       = OW'(idx) & ~(OW'(1) << l);
      end
    end
  end
endmodule

// File: rtl/bheap_store.sv
module bheap_store
  import bheap_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int KEY_W  = 8,
  parameter int TAG_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  heapStrobeT             stb,
  input  logic [LEVELS-1:0]      cur,
  input  logic [LEVELS-1:0]      count,
  input  logic [KEY_W-1:0]       inKey,
  input  logic [TAG_W-1:0]       inTag,
  output logic                   upGo,
  output logic                   downGo,
  output logic [LEVELS-1:0]      childIdx,
  output logic [KEY_W+TAG_W-1:0] rootEnt,
  output logic [KEY_W+TAG_W-1:0] rspEnt
);
  localparam int ENT_W = KEY_W + TAG_W;
  localparam int IW    = LEVELS + 1;
  localparam int OW    = LEVELS - 1;
  localparam int NRD   = 5;
  localparam int NDEC  = NRD + 2;
  localparam int WA    = NRD;
  localparam int WB    = NRD + 1;

  logic [IW-1:0]     idxD   [NDEC];
  logic [LEVELS-1:0] selD   [NDEC];
  logic [OW-1:0]     offD   [NDEC];
  logic [ENT_W-1:0]  lvlRd  [NRD][LEVELS];
  logic [ENT_W-1:0]  ent    [NRD];
  logic [ENT_W-1:0]  wrDatA, wrDatB;
  logic [IW-1:0]     wrIdxA, wrIdxB;
  logic              wrEnA, wrEnB;
  logic [IW-1:0]     curW, cntW;

  assign curW    = IW'(cur);
  assign cntW    = IW'(count);
  assign idxD[0] = curW;
  assign idxD[1] = curW >> 1;
  assign idxD[2] = curW << 1;
  assign idxD[3] = (curW << 1) | IW'(1);
  assign idxD[4] = cntW;
  assign idxD[WA] = wrIdxA;
  assign idxD[WB] = wrIdxB;

  for (genvar k = 0; k < NDEC; k++) begin : g_dec
    bheap_addr_dec #(.LEVELS(LEVELS), .IW(IW)) dec_i (
      .idx(idxD[k]), .lvlSel(selD[k]), .off(offD[k])
    );
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int AW = (l == 0) ? 1 : l;
    logic [ENT_W-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
      if (wrEnA && selD[WA][l]) mem[offD[WA][AW-1:0]] <= wrDatA;
      else if (wrEnB && selD[WB][l]) mem[offD[WB][AW-1:0]] <= wrDatB;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign lvlRd[k][l] = mem[offD[k][AW-1:0]];
    end
  end

  assign rootEnt = g_lvl[0].mem[0];

  always_comb begin
    for (int k = 0; k < NRD; k++) begin
      ent[k] = '0;
      for (int l = 0; l < LEVELS; l++)
        if (selD[k][l]) ent[k] = lvlRd[k][l];
    end
  end

  // comparison logic
  logic [KEY_W-1:0] nodeKey, parKey, lKey, rKey;
  logic             lOk, rOk, pickRight;
  logic [ENT_W-1:0] childEnt;
  logic [IW-1:0]    childW;

  assign nodeKey   = ent[0][ENT_W-1 -: KEY_W];
  assign parKey    = ent[1][ENT_W-1 -: KEY_W];
  assign lKey      = ent[2][ENT_W-1 -: KEY_W];
  assign rKey      = ent[3][ENT_W-1 -: KEY_W];
  assign lOk       = idxD[2] <= cntW;
  assign rOk       = idxD[3] <= cntW;
  assign pickRight = rOk && (rKey > lKey);
  assign childW    = pickRight ? idxD[3] : idxD[2];
  assign childEnt  = pickRight ? ent[3] : ent[2];
  assign childIdx  = LEVELS'(childW);
  assign upGo      = (curW > IW'(1)) && (nodeKey > parKey);
  assign downGo    = lOk && (childEnt[ENT_W-1 -: KEY_W] > nodeKey);

  // write port selection
  always_comb begin
    wrEnA = 1'b0; wrIdxA = '0; wrDatA = '0;
    wrEnB = 1'b0; wrIdxB = '0; wrDatB = '0;
    if (stb.enqWr) begin
      wrEnA = 1'b1; wrIdxA = cntW + IW'(1); wrDatA = {inKey, inTag};
    end else if (stb.deqStart) begin
      wrEnA = 1'b1; wrIdxA = IW'(1); wrDatA = ent[4];
    end else if (stb.swapUp) begin
      wrEnA = 1'b1; wrIdxA = idxD[1]; wrDatA = ent[0];
      wrEnB = 1'b1; wrIdxB = curW;    wrDatB = ent[1];
    end else if (stb.swapDown) begin
      wrEnA = 1'b1; wrIdxA = childW;  wrDatA = ent[0];
      wrEnB = 1'b1; wrIdxB = curW;    wrDatB = childEnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rspEnt <= '0;
    else if (stb.rspLoad) rspEnt <= rootEnt;
  end
endmodule

// File: rtl/bheap_ctrl.sv
module bheap_ctrl
  import bheap_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              upGo,
  input  logic              downGo,
  input  logic [LEVELS-1:0] childIdx,
  output heapStrobeT        stb,
  output logic [LEVELS-1:0] cur,
  output logic [LEVELS-1:0] count,
  output logic              cmdReady,
  output logic              busy,
  output logic              rspValid,
  output logic              cmdErr
);
  localparam int CW  = LEVELS;
  localparam int CAP = (1 << LEVELS) - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_UP, ST_DOWN} stateE;
  stateE  state;
  heapOpE op;
  logic   accept, isFull, isEmpty, errNext;

  assign op       = heapOpE'(cmdOp);
  assign cmdReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign isFull   = (count == CW'(CAP));
  assign isEmpty  = (count == '0);

  always_comb begin
    stb     = '0;
    errNext = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        case (op)
          OP_ENQ:  if (isFull) errNext = 1'b1; else stb.enqWr = 1'b1;
          OP_DEQ:  if (isEmpty) errNext = 1'b1;
                   else begin stb.deqStart = 1'b1; stb.rspLoad = 1'b1; end
          OP_PEEK: if (isEmpty) errNext = 1'b1; else stb.rspLoad = 1'b1;
          default: ;
        endcase
      end
      ST_UP:   stb.swapUp   = upGo;
      ST_DOWN: stb.swapDown = downGo;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cur      <= CW'(1);
      count    <= '0;
      rspValid <= 1'b0;
      cmdErr   <= 1'b0;
    end else begin
      rspValid <= stb.rspLoad;
      cmdErr   <= errNext;
      case (state)
        ST_IDLE: begin
          if (stb.enqWr) begin
            count <= count + CW'(1);
            cur   <= count + CW'(1);
            state <= ST_UP;
          end else if (stb.deqStart) begin
            count <= count - CW'(1);
            cur   <= CW'(1);
            state <= ST_DOWN;
          end
        end
        ST_UP:   if (upGo) cur <= cur >> 1; else state <= ST_IDLE;
        ST_DOWN: if (downGo) cur <= childIdx; else state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bheap_pq.sv
module bheap_pq
  import bheap_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int KEY_W  = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [KEY_W-1:0]  cmdKey,
  input  logic [TAG_W-1:0]  cmdTag,
  output logic              rspValid,
  output logic [KEY_W-1:0]  rspKey,
  output logic [TAG_W-1:0]  rspTag,
  output logic              cmdErr,
  output logic              topValid,
  output logic [KEY_W-1:0]  topKey,
  output logic [TAG_W-1:0]  topTag,
  output logic [LEVELS-1:0] count,
  output logic              full,
  output logic              empty,
  output logic              busy
);
  localparam int ENT_W = KEY_W + TAG_W;
  localparam int CAP   = (1 << LEVELS) - 1;

  heapStrobeT        stb;
  logic [LEVELS-1:0] cur, childIdx;
  logic              upGo, downGo;
  logic [ENT_W-1:0]  rootEnt, rspEnt;

  bheap_ctrl #(.LEVELS(LEVELS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .upGo(upGo), .downGo(downGo), .childIdx(childIdx),
    .stb(stb), .cur(cur), .count(count), .cmdReady(cmdReady),
    .busy(busy), .rspValid(rspValid), .cmdErr(cmdErr)
  );

  bheap_store #(.LEVELS(LEVELS), .KEY_W(KEY_W), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cur(cur), .count(count),
    .inKey(cmdKey), .inTag(cmdTag), .upGo(upGo), .downGo(downGo),
    .childIdx(childIdx), .rootEnt(rootEnt), .rspEnt(rspEnt)
  );

  assign full     = (count == LEVELS'(CAP));
  assign empty    = (count == '0);
  assign topValid = !empty && !busy;
  assign topKey   = rootEnt[ENT_W-1 -: KEY_W];
  assign topTag   = rootEnt[TAG_W-1:0];
  assign rspKey   = rspEnt[ENT_W-1 -: KEY_W];
  assign rspTag   = rspEnt[TAG_W-1:0];
endmodule

// File: rtl/bheap_pq_chk.sv
module bheap_pq_chk #(
  parameter int LEVELS = 4,
  parameter int KEY_W  = 8,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdOp,
  input logic [KEY_W-1:0]  cmdKey,
  input logic [TAG_W-1:0]  cmdTag,
  input logic              rspValid,
  input logic [KEY_W-1:0]  rspKey,
  input logic [TAG_W-1:0]  rspTag,
  input logic              cmdErr,
  input logic              topValid,
  input logic [KEY_W-1:0]  topKey,
  input logic [TAG_W-1:0]  topTag,
  input logic [LEVELS-1:0] count,
  input logic              full,
  input logic              empty,
  input logic              busy
);
  logic [7:0] busyRun;
  logic       acc;

  assign acc = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 8'd1;
    else           busyRun <= '0;
  end

  a_r2_count_inc: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == 2'b01 && !full |=> count == $past(count) + 1'b1);

  a_r4_deq_root: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == 2'b10 && !empty |=> rspValid && rspKey == $past(topKey));

  a_r7_full_reject: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == 2'b01 && full |=> cmdErr && !rspValid && $stable(count));

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> count == $past(count));

  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 8'(LEVELS));

  a_r11_noop: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == 2'b00 |=> !rspValid && !cmdErr && $stable(count));
endmodule

bind bheap_pq bheap_pq_chk #(.LEVELS(LEVELS), .KEY_W(KEY_W), .TAG_W(TAG_W)) chk_i (.*);

// File: tb/bheap_pq_tb_top.sv
`timescale 1ns/1ps
module bheap_pq_tb_top;
  localparam int LEVELS = 4;
  localparam int KEY_W  = 8;
  localparam int TAG_W  = 4;
  localparam int CAP    = (1 << LEVELS) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [KEY_W-1:0] cmdKey = '0;
  logic [TAG_W-1:0] cmdTag = '0;
  logic cmdReady, rspValid, cmdErr, topValid, full, empty, busy;
  logic [KEY_W-1:0] rspKey, topKey;
  logic [TAG_W-1:0] rspTag, topTag;
  logic [LEVELS-1:0] count;

  always #2.5 clk = ~clk;

  bheap_pq #(.LEVELS(LEVELS), .KEY_W(KEY_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdKey(cmdKey), .cmdTag(cmdTag), .rspValid(rspValid),
    .rspKey(rspKey), .rspTag(rspTag), .cmdErr(cmdErr), .topValid(topValid),
    .topKey(topKey), .topTag(topTag), .count(count), .full(full),
    .empty(empty), .busy(busy)
  );

  int nChecks = 0;
  int nErrs   = 0;
  int mKey [CAP];
  int mTag [CAP];
  int mCnt = 0;
  logic [KEY_W+TAG_W-1:0] expQ [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int maxIdx();
    int b = 0;
    for (int i = 1; i < mCnt; i++) if (mKey[i] > mKey[b]) b = i;
    return b;
  endfunction

  // monitor: pops expected responses
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) check(1'b0, "R3/R4 unexpected response", int'(rspKey), -1);
      else begin
        logic [KEY_W+TAG_W-1:0] e;
        e = expQ.pop_front();
        check(rspKey == e[KEY_W+TAG_W-1 -: KEY_W], "R4/R5 response key",
              int'(rspKey), int'(e[KEY_W+TAG_W-1 -: KEY_W]));
        check(rspTag == e[TAG_W-1:0], "R6 response tag", int'(rspTag), int'(e[TAG_W-1:0]));
      end
    end
  end

  task automatic issue(input logic [1:0] op, input int k, input int t);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdKey = KEY_W'(k); cmdTag = TAG_W'(t);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n <= LEVELS, "R9 busy length", n, LEVELS);
  endtask

  task automatic doEnq(input int k, input int t);
    bit expErr = (mCnt == CAP);
    issue(2'b01, k, t);
    check(cmdErr == expErr, "R7 insert error flag", int'(cmdErr), int'(expErr));
    if (!expErr) begin
      check(busy && !cmdReady, "R8 busy after insert", int'(busy), 1);
      mKey[mCnt] = k; mTag[mCnt] = t; mCnt++;
      waitIdle();
      check(topKey == KEY_W'(mKey[maxIdx()]), "R2 top is max", int'(topKey), mKey[maxIdx()]);
    end
    check(count == LEVELS'(mCnt), "R2/R7 count after insert", int'(count), mCnt);
  endtask

  task automatic doDeq();
    bit expErr = (mCnt == 0);
    if (!expErr) begin
      int b = maxIdx();
      expQ.push_back({KEY_W'(mKey[b]), TAG_W'(mTag[b])});
      for (int i = b; i < mCnt - 1; i++) begin mKey[i] = mKey[i+1]; mTag[i] = mTag[i+1]; end
      mCnt--;
    end
    issue(2'b10, 0, 0);
    check(cmdErr == expErr, "R7 remove error flag", int'(cmdErr), int'(expErr));
    if (!expErr) check(rspValid && busy, "R4 immediate response and busy", int'(rspValid), 1);
    else check(!rspValid, "R7 no response when empty", int'(rspValid), 0);
    waitIdle();
    check(count == LEVELS'(mCnt), "R4 count after remove", int'(count), mCnt);
  endtask

  task automatic doPeek();
    bit expErr = (mCnt == 0);
    if (!expErr) expQ.push_back({KEY_W'(mKey[maxIdx()]), TAG_W'(mTag[maxIdx()])});
    issue(2'b11, 0, 0);
    check(cmdErr == expErr, "R7 look error flag", int'(cmdErr), int'(expErr));
    check(!busy, "R3 look does not set busy", int'(busy), 0);
    check(count == LEVELS'(mCnt), "R3 count after look", int'(count), mCnt);
  endtask

  task automatic doReset();
    cmdValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0;
    @(negedge clk);
    check(count == 0 && empty && !full, "R1 reset counters", int'(count), 0);
    check(!busy && cmdReady && !topValid, "R1 reset handshake", int'(busy), 0);
    check(!rspValid && !cmdErr, "R1 reset strobes", int'(rspValid), 0);
  endtask

  initial begin
    #1000000;
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    doReset();

    // R11: no-op handshake
    issue(2'b00, 77, 1);
    check(!rspValid && !cmdErr && count == 0, "R11 no-op ignored", int'(count), 0);

    // R7: empty rejects
    doDeq();
    doPeek();

    // R2: fill partly
    doEnq(40, 1); doEnq(10, 2); doEnq(70, 3); doEnq(25, 4);
    doEnq(90, 5); doEnq(5, 6);  doEnq(60, 7);
    check(topValid, "R10 topValid when idle non-empty", int'(topValid), 1);

    // R8: command held during a deep climb
    issue(2'b01, 200, 8);
    mKey[mCnt] = 200; mTag[mCnt] = 8; mCnt++;
    check(busy && !cmdReady && !topValid, "R8 ready low while climbing", int'(cmdReady), 0);
    cmdValid = 1'b1; cmdOp = 2'b10;
    @(negedge clk);
    check(!rspValid && count == LEVELS'(mCnt), "R8 held command not taken", int'(rspValid), 0);
    cmdValid = 1'b0; cmdOp = 2'b00;
    waitIdle();
    check(topKey == 8'd200, "R2 new max reaches root", int'(topKey), 200);
    doPeek();

    // fill to capacity
    doEnq(15, 9); doEnq(33, 10); doEnq(81, 11); doEnq(47, 12);
    doEnq(3, 13); doEnq(99, 14); doEnq(120, 15);
    check(full && !empty, "R10 full at capacity", int'(full), 1);
    doEnq(250, 0); // R7 rejected when full

    // R5: drain in descending order
    for (int i = 0; i < CAP; i++) doDeq();
    check(empty && !full, "R10 empty after drain", int'(empty), 1);

    // interleaved inserts and removals with distinct keys
    for (int i = 1; i <= 40; i++) begin
      if (i % 3 == 2) doDeq();
      else doEnq((i * 37) % 256, i % 16);
    end
    while (mCnt > 0) doDeq();

    // R6: equal keys
    doReset();
    doEnq(50, 1);
    doEnq(50, 2);
    check(topTag == 4'd1, "R6 equal key not swapped", int'(topTag), 1);
    doEnq(50, 3);
    check(topTag == 4'd1, "R6 first equal stays on top", int'(topTag), 1);
    expQ.push_back({8'd50, 4'd1});
    issue(2'b10, 0, 0); waitIdle();
    check(topTag == 4'd3, "R6 moved-up last stays at root", int'(topTag), 3);
    expQ.push_back({8'd50, 4'd3});
    issue(2'b10, 0, 0); waitIdle();
    expQ.push_back({8'd50, 4'd2});
    issue(2'b10, 0, 0); waitIdle();
    check(empty, "R10 empty after tie drain", int'(empty), 1);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 all responses seen", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule